// File: doc/BRIEF.md
# Preamplifier Serial Control Port

This block is the digital control port of a programmable-gain microphone preamplifier. A host drives a select line (active low), a serial clock and a data line. While select is low, each rising serial-clock edge shifts one bit into a 16-bit shift register, most significant bit first. When select returns high, the word is decoded and loaded into the control register. That register drives the servo, zero-crossing and over-range threshold controls, four general-purpose outputs and a gain step index.

The serial output always carries the most significant bit of the shift register and is updated on falling serial-clock edges. Its pad enable is asserted only while select is low, so the pad is high-impedance otherwise. Several ports can therefore be chained into one long shift register. Programming N chained ports takes 16×N clocks inside one select window, with the word for the far end sent first. Contents shifted out of a single port read back the word that was previously loaded.

All three serial inputs are brought into the system clock domain through multi-flop synchronisers. Edges are detected in the system clock domain, which must run at least four times faster than the serial clock.

Top module: `preamp_ctl_port`

## Requirements
- R1: Word bit 15 drives `servo_dc_off` (1 disables the dc servo), bit 14 drives `cm_servo_en`, bit 13 drives `zc_en`, bit 12 drives `ovr_low_thr` (0 selects the higher threshold, 1 the lower), and bits 11..8 drive `gpo[3]..gpo[0]`. Bits 5..0 are the gain code N.
- R2: While select is low, the data line is sampled on each rising serial-clock edge and enters the shift register at bit 0. The first bit sent ends up at bit 15.
- R3: The control outputs change only when select rises, and then take the decoded value of the shift register. Mid-transfer they keep their previous values.
- R4: While select is high, serial-clock and data activity does not alter the shift register or the outputs.
- R5: `sdout_oe` is 0 while select is high and 1 while select is low.
- R6: `sdout` presents shift-register bit 15. It is loaded when select falls and on every falling serial-clock edge while selected. A 16-clock transfer therefore reads back the previous 16-bit contents, MSB first.
- R7: In a transfer of 32 clocks, `sdout` first carries the previous contents and then the first 16 bits sent. The control outputs take the last 16 bits sent.
- R8: Gain code N=0 gives `gain_unity`=1 and `gain_idx`=0. N from 1 to 17 gives `gain_unity`=0 and `gain_idx`=N, meaning 6+3·N dB.
- R9: Gain codes 18 to 63 give `gain_unity`=0 and `gain_idx`=18 (60 dB).
- R10: After reset, the control register decodes an all-zero word: every flag and `gpo` output is 0, `gain_unity`=1, `gain_idx`=0, and `sdout_oe`=0.
- R11: Word bits 7..6 have no effect on any control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Serial select, active low; its rising edge loads the word |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out (shift register MSB) |
| sdout_oe | output | 1 | Pad enable for sdout; low means high-impedance |
| servo_dc_off | output | 1 | 1 disables the dc servo |
| cm_servo_en | output | 1 | Common-mode servo enable |
| zc_en | output | 1 | Zero-crossing gain switching enable |
| ovr_low_thr | output | 1 | Selects the lower over-range threshold |
| gpo | output | 4 | General-purpose output levels |
| gain_unity | output | 1 | Unity (0 dB) gain selected |
| gain_idx | output | 5 | Gain step index, 0 to 18 |

## Verification
On every cycle, the assertions check four things. The gain index never exceeds 18, and unity gain is only ever paired with index zero. The control outputs hold steady except in the cycle after a load pulse. The shift register and the serial output move only on their detected edges, and the shift register is frozen while select is high. Field positions, the gain mapping values, MSB-first readback of the old word, and daisy-chain pass-through depend on complete serial sequences. Only the bench's transfers can show those.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
   localparam int GPO_W    = 4;
   localparam int GAIN_W   = 6;
   localparam int PAD_W    = 2;
   localparam int FLAG_W   = 4;
   localparam int STEP_W   = 5;
   localparam int MAX_LIN  = 17;
   localparam int SAT_STEP = 18;
   localparam int WORD_W   = FLAG_W + GPO_W + PAD_W + GAIN_W;
   localparam int FIELD_W  = WORD_W - PAD_W;

   typedef struct packed {
      logic              dc_off;
      logic              cm_en;
      logic              zc_en;
      logic              ovr_low;
      logic [GPO_W-1:0]  gpo;
      logic              unity;
      logic [STEP_W-1:0] step;
   } ctrl_t;

   // returns {unity, step}
   function automatic logic [STEP_W:0] gain_map(input logic [GAIN_W-1:0] code);
      if (code == '0)
         gain_map = {1'b1, {STEP_W{1'b0}}};
      else if (int'(code) <= MAX_LIN)
         gain_map = {1'b0, code[STEP_W-1:0]};
      else
         gain_map = {1'b0, STEP_W'(SAT_STEP)};
   endfunction
endpackage

// File: rtl/pctl_sync.sv
module pctl_sync #(
   parameter int         STAGES  = 2,
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= d_in;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/pctl_shifter.sv
module pctl_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_evt,
   input  logic              out_evt,
   input  logic              din,
   output logic [WORD_W-1:0] shreg,
   output logic              dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         dout  <= 1'b0;
      end else begin
         if (shift_evt) shreg <= {shreg[WORD_W-2:0], din};
         if (out_evt)   dout  <= shreg[WORD_W-1];
      end
   end
endmodule

// File: rtl/pctl_decode.sv
module pctl_decode
   import pctl_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FIELD_W-1:0] fields,
   output ctrl_t              ctrl
);
   localparam int GAIN_LO = 0;
   localparam int GPO_LO  = GAIN_W;
   localparam int FLAG_LO = GAIN_W + GPO_W;

   ctrl_t nxt;
   logic [STEP_W:0] gm;

   always_comb begin
      gm          = gain_map(fields[GAIN_LO +: GAIN_W]);
      nxt.dc_off  = fields[FLAG_LO+3];
      nxt.cm_en   = fields[FLAG_LO+2];
      nxt.zc_en   = fields[FLAG_LO+1];
      nxt.ovr_low = fields[FLAG_LO];
      nxt.gpo     = fields[GPO_LO +: GPO_W];
      nxt.unity   = gm[STEP_W];
      nxt.step    = gm[STEP_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl       <= '0;
         ctrl.unity <= 1'b1;
      end else if (load) begin
         ctrl <= nxt;
      end
   end
endmodule

// File: rtl/preamp_ctl_port.sv
module preamp_ctl_port
   import pctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic              sdout,
   output logic              sdout_oe,
   output logic              servo_dc_off,
   output logic              cm_servo_en,
   output logic              zc_en,
   output logic              ovr_low_thr,
   output logic [GPO_W-1:0]  gpo,
   output logic              gain_unity,
   output logic [STEP_W-1:0] gain_idx
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WORD_W != 16) begin : g_bad_word
         $error("control word must be 16 bits");
      end
      if ((1 << STEP_W) <= SAT_STEP) begin : g_bad_step
         $error("STEP_W too narrow for saturated step");
      end
   endgenerate

   logic [2:0] raw_in, syn;
   logic       sel_s, sclk_s, sdin_s;
   logic       sel_q, sclk_q;
   logic       sclk_rise, sclk_fall, sel_rise, sel_fall;
   logic [WORD_W-1:0] shreg;
   ctrl_t      ctrl;

   assign raw_in = {sel_n, sclk, sdin};

   pctl_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q_out(syn)
   );
   assign {sel_s, sclk_s, sdin_s} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         sel_q  <= sel_s;
         sclk_q <= sclk_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q & ~sel_s;
   assign sclk_fall = ~sclk_s & sclk_q & ~sel_s;
   assign sel_rise  = sel_s & ~sel_q;
   assign sel_fall  = ~sel_s & sel_q;

   pctl_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .shift_evt(sclk_rise), .out_evt(sclk_fall | sel_fall),
      .din(sdin_s), .shreg(shreg), .dout(sdout)
   );

   pctl_decode u_dec (
      .clk(clk), .rst_n(rst_n), .load(sel_rise),
      .fields({shreg[WORD_W-1:GAIN_W+PAD_W], shreg[GAIN_W-1:0]}),
      .ctrl(ctrl)
   );

   assign sdout_oe     = ~sel_s;
   assign servo_dc_off = ctrl.dc_off;
   assign cm_servo_en  = ctrl.cm_en;
   assign zc_en        = ctrl.zc_en;
   assign ovr_low_thr  = ctrl.ovr_low;
   assign gpo          = ctrl.gpo;
   assign gain_unity   = ctrl.unity;
   assign gain_idx     = ctrl.step;
endmodule

// File: rtl/pctl_checker.sv
module pctl_checker
   import pctl_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              sel_s,
   input logic              load,
   input logic              shift_evt,
   input logic              out_evt,
   input logic [WORD_W-1:0] shreg,
   input logic              sdout,
   input ctrl_t             ctrl
);
   assert_gain_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ctrl.step) <= SAT_STEP);

   assert_unity_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.unity |-> (ctrl.step == '0));

   assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ctrl));

   assert_shreg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> $stable(shreg));

   assert_shreg_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_evt |=> $stable(shreg));

   assert_sdout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_evt |=> $stable(sdout));
endmodule

bind preamp_ctl_port pctl_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .load(sel_rise),
   .shift_evt(sclk_rise), .out_evt(sclk_fall | sel_fall),
   .shreg(shreg), .sdout(sdout), .ctrl(ctrl)
);

// File: tb/preamp_ctl_port_tb.sv
module preamp_ctl_port_tb;
   localparam int H = 5;

   logic clk = 0, rst_n = 0, sel_n = 1, sclk = 0, sdin = 0;
   logic sdout, sdout_oe, servo_dc_off, cm_servo_en, zc_en, ovr_low_thr, gain_unity;
   logic [3:0] gpo;
   logic [4:0] gain_idx;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [15:0] sh_model = '0;
   logic [15:0] cur = '0;
   logic [63:0] cap;

   always #5 clk = ~clk;

   preamp_ctl_port u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
      .sdout(sdout), .sdout_oe(sdout_oe), .servo_dc_off(servo_dc_off),
      .cm_servo_en(cm_servo_en), .zc_en(zc_en), .ovr_low_thr(ovr_low_thr),
      .gpo(gpo), .gain_unity(gain_unity), .gain_idx(gain_idx)
   );

   // {dc, cm, zc, or, gpo[3:0], unity, idx[4:0]}
   function automatic logic [13:0] expect_out(input logic [15:0] w);
      logic [5:0] n = w[5:0];
      logic       u;
      logic [4:0] ix;
      if (n == 0)       begin u = 1; ix = 0; end
      else if (n < 18)  begin u = 0; ix = n[4:0]; end
      else              begin u = 0; ix = 5'd18; end
      return {w[15], w[14], w[13], w[12], w[11:8], u, ix};
   endfunction

   function automatic logic [13:0] actual_out();
      return {servo_dc_off, cm_servo_en, zc_en, ovr_low_thr, gpo, gain_unity, gain_idx};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [63:0] data, input int nbits, input string req);
      @(negedge clk) sel_n = 0;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk) sdin = data[nbits-1-i];
         repeat (H) @(negedge clk);
         cap[nbits-1-i] = sdout;
         if (i == 0) chk(32'(sdout_oe), 1, "R5 oe during select");
         sclk = 1;
         repeat (H) @(negedge clk);
         sclk = 0;
      end
      repeat (H) @(negedge clk);
      chk(32'(actual_out()), 32'(expect_out(cur)), {"R3 hold before load ", req});
      sel_n = 1;
      repeat (8) @(negedge clk);
      chk(32'(sdout_oe), 0, "R5 oe after deselect");
   endtask

   task automatic write_word(input logic [15:0] w, input string req);
      xfer({48'd0, w}, 16, req);
      chk(32'(cap[15:0]), 32'(sh_model), "R6 readback of previous word");
      chk(32'(actual_out()), 32'(expect_out(w)), req);
      sh_model = w;
      cur = w;
   endtask

   initial begin
      automatic int unsigned seed = 32'h5EED_1234;
      logic [15:0] a, b;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk(32'(actual_out()), 32'(expect_out(16'h0000)), "R10 reset outputs");
      chk(32'(sdout_oe), 0, "R10 reset oe");

      // flag fields one at a time
      write_word(16'h8000, "R1 dc bit");
      write_word(16'h4000, "R1 cm bit");
      write_word(16'h2000, "R1 zc bit");
      write_word(16'h1000, "R1 or bit");
      write_word(16'h0900, "R1 gpo D4 D1");
      write_word(16'h0600, "R1 gpo D3 D2");
      write_word(16'h00C0, "R11 pad bits ignored");
      write_word(16'hA5C5, "R11 pad bits with fields");
      write_word(16'h0001, "R2 msb-first lsb");

      // gain map corners
      write_word(16'h0000, "R8 code 0 unity");
      write_word(16'h0001, "R8 code 1");
      write_word(16'h0002, "R8 code 2");
      write_word(16'h0011, "R8 code 17");
      write_word(16'h0012, "R9 code 18");
      write_word(16'h001F, "R9 code 31");
      write_word(16'h0020, "R9 code 32");
      write_word(16'hF03F, "R9 code 63");

      // ignored while deselected
      write_word(16'h3A05, "R1 setup for R4");
      for (int i = 0; i < 16; i++) begin
         @(negedge clk) sdin = 1'($urandom);
         repeat (H) @(negedge clk) sclk = 1;
         repeat (H) @(negedge clk) sclk = 0;
      end
      repeat (8) @(negedge clk);
      chk(32'(actual_out()), 32'(expect_out(16'h3A05)), "R4 outputs unchanged");
      chk(32'(sdout_oe), 0, "R4 R5 oe low while deselected");
      write_word(16'h5555, "R4 shift register unchanged (readback)");

      // daisy chain of two
      a = 16'hC3A7;
      b = 16'h1E09;
      xfer({32'd0, a, b}, 32, "R7 chain");
      chk(32'(cap[31:16]), 32'(sh_model), "R7 old contents first");
      chk(32'(cap[15:0]), 32'(a), "R7 far word passes through");
      chk(32'(actual_out()), 32'(expect_out(b)), "R7 near word loaded");
      sh_model = b;
      cur = b;

      // random words
      for (int i = 0; i < 30; i++) begin
         a = 16'($urandom);
         write_word(a, "R1 R8 random word");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule